// File: doc/BRIEF.md
# Storage Host Port Register File with Interrupt Aggregation

This block is the software-visible register file of a multi-port storage host controller. A processor reaches it through 32-bit aligned reads and writes on a simple address/data interface. The block holds the controller-wide capability, control, interrupt summary, implemented-ports and version words. It also holds one register set per port: interrupt causes, interrupt enables, command/status, link status, link control, link error and active-tag registers.

The command engine reports interrupt causes and link errors on per-port input vectors. The block ANDs each port's causes with that port's enables and folds the result into a sticky controller-wide summary. From the summary and a global enable it drives a single registered level interrupt. Writing the control register's reset bit restarts the whole controller. A one-to-zero transition of a port's link-control detect field restarts that port only, and the engine sees this as a one-cycle pulse.

Top module: `hba_reg_file`

## Requirements
- R1: Only address bits 11:0 are decoded. Offsets below 0x20 select controller registers: capability 0x00, control 0x04, interrupt summary 0x08, implemented ports 0x0C, version 0x10. Port p occupies 0x80 bytes starting at 0x100 + 0x80*p, with the port index taken as (offset-0x100)>>7. A read of an unknown offset, or of a port index at or above NPORTS, returns 0.
- R2: A write whose address bits 1:0 are not zero changes no register.
- R3: Capability reads NPORTS-1 in bits 4:0, SLOTS-1 in bits 12:8, bit 18 (AHCI-only operation), speed value 1 in bits 23:20, and bit 30 (NCQ support). Implemented ports reads (1<<NPORTS)-1. Version reads 0x00010000.
- R4: A control write with bit 0 clear stores bits 1:0 of the data and forces bit 31 to 1. Bit 1 is the global interrupt enable.
- R5: A port's cause register (port offset 0x10) ORs in the cause input bits every cycle. A write clears each bit written as 1 and keeps the others.
- R6: A write to a port's enable register (offset 0x14) stores the data ANDed with 0xFDC000FF.
- R7: Summary bit i is set one cycle after port i has a bit that is both set and enabled. It stays set until a 1 is written to it, and it sets again while the cause is still pending.
- R8: irq_o is high one cycle after the summary is nonzero while control bit 1 is set, and low one cycle after either condition fails.
- R9: A port's command register (offset 0x18) resets to 0x6. On a write, bit 15 takes the value of written bit 0, bit 14 takes the value of written bit 4, and the written values of bits 15 and 14 are discarded. port_run_o mirrors bit 15.
- R10: A port's link status register (offset 0x28) reads 0x113 when that port's present input is high, and 0 otherwise.
- R11: A port's link error register (offset 0x30) ORs in the error input bits and is write-1-to-clear. Its active register (offset 0x34) is write-1-to-set.
- R12: A write to link control (offset 0x2C) that changes bits 3:0 from 1 to 0 resets the port. Cause, enable, error and active are cleared, link control takes the written value, the command register is kept, and port_rst_o pulses for one cycle. Other link-control writes only store the value.
- R13: A control write with bit 0 set clears control and the summary, and resets every port as in R12, except that link control is also cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| port_evt_i | input | 32*NPORTS | Per-port interrupt causes to set, port p at bits 32p+31:32p |
| port_err_i | input | 32*NPORTS | Per-port link error bits to set |
| port_present_i | input | NPORTS | Device present on each port's link |
| port_run_o | output | NPORTS | Command-list running status of each port |
| port_rst_o | output | NPORTS | One-cycle pulse after a port reset |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Every cycle, the assertions check the interrupt pipeline. irq_o must follow the summary and the enable one cycle later. A summary bit may fall only after a clearing write or a controller reset, and a bit must be set whenever the matching port was pending. They also check that a misaligned write never alters the control register. The bench scenarios cover the rest: the masking of the enable register, the status mirroring in the command register, the difference between a detect 1-to-0 transition and any other link-control write, the reset of every port by the control register, and the decode of high address bits and unused offsets. These depend on data values and write sequences that a single-cycle property cannot hold.

// File: rtl/hba_regs_pkg.sv
package hba_regs_pkg;
  // controller offsets
  localparam logic [6:0] G_CAP = 7'h00;
  localparam logic [6:0] G_CTL = 7'h04;
  localparam logic [6:0] G_SUM = 7'h08;
  localparam logic [6:0] G_IMP = 7'h0C;
  localparam logic [6:0] G_VER = 7'h10;
  // port offsets
  localparam logic [6:0] P_CAUSE = 7'h10;
  localparam logic [6:0] P_ENA   = 7'h14;
  localparam logic [6:0] P_CMD   = 7'h18;
  localparam logic [6:0] P_LSTAT = 7'h28;
  localparam logic [6:0] P_LCTL  = 7'h2C;
  localparam logic [6:0] P_LERR  = 7'h30;
  localparam logic [6:0] P_ACT   = 7'h34;

  localparam int unsigned HOST_LIMIT = 32'h20;
  localparam int unsigned PORT_BASE  = 32'h100;
  localparam int unsigned PORT_SPAN  = 32'h80;

  localparam logic [31:0] ENA_MASK    = 32'hFDC0_00FF;
  localparam logic [31:0] CMD_RST_VAL = 32'h0000_0006;
  localparam logic [31:0] LINK_UP_VAL = 32'h0000_0113;
  localparam logic [31:0] VER_VAL     = 32'h0001_0000;

  localparam int CMD_START = 0;
  localparam int CMD_RXEN  = 4;
  localparam int CMD_RXRUN = 14;
  localparam int CMD_RUN   = 15;

  function automatic logic [31:0] cap_word(int unsigned nports, int unsigned slots);
    logic [31:0] v;
    v = '0;
    v[4:0]   = 5'(nports - 1);
    v[12:8]  = 5'(slots - 1);
    v[18]    = 1'b1;
    v[23:20] = 4'd1;
    v[30]    = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/hba_addr_dec.sv
module hba_addr_dec
  import hba_regs_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              glob_hit_o,
  output logic              port_hit_o,
  output logic [4:0]        port_idx_o,
  output logic [6:0]        off_o,
  output logic              aligned_o
);
  localparam int unsigned SPAN_END = PORT_BASE + NPORTS * PORT_SPAN;

  logic [11:0] a, rel;
  logic        unused_bits;

  assign a           = addr_i[11:0];
  assign rel         = a - 12'(PORT_BASE);
  assign glob_hit_o  = 32'(a) < HOST_LIMIT;
  assign port_hit_o  = (32'(a) >= PORT_BASE) && (32'(a) < SPAN_END);
  assign port_idx_o  = rel[11:7];
  assign off_o       = a[6:0];
  assign aligned_o   = (a[1:0] == 2'b00);
  assign unused_bits = &{1'b0, addr_i[ADDR_W-1:12], rel[6:0]};
endmodule

// File: rtl/hba_port_regs.sv
module hba_port_regs
  import hba_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        wr_i,
  input  logic [6:0]  off_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] evt_i,
  input  logic [31:0] err_i,
  input  logic        present_i,
  output logic [31:0] rdata_o,
  output logic        pend_o,
  output logic        run_o,
  output logic        port_rst_o
);
  logic [31:0] cause_q, ena_q, cmd_q, lctl_q, lerr_q, act_q;
  logic [31:0] cmd_wr, cause_clr, lerr_clr;
  logic        wr_cause, wr_ena, wr_cmd, wr_lctl, wr_lerr, wr_act;
  logic        det_fall, wipe, rst_q;

  assign wr_cause = wr_i && (off_i == P_CAUSE);
  assign wr_ena   = wr_i && (off_i == P_ENA);
  assign wr_cmd   = wr_i && (off_i == P_CMD);
  assign wr_lctl  = wr_i && (off_i == P_LCTL);
  assign wr_lerr  = wr_i && (off_i == P_LERR);
  assign wr_act   = wr_i && (off_i == P_ACT);

  assign det_fall = wr_lctl && (lctl_q[3:0] == 4'd1) && (wdata_i[3:0] == 4'd0);
  assign wipe     = clr_i || det_fall;

  assign cause_clr = wr_cause ? wdata_i : '0;
  assign lerr_clr  = wr_lerr ? wdata_i : '0;

  // running bits follow their enables, never the written value
  always_comb begin
    cmd_wr            = wdata_i;
    cmd_wr[CMD_RUN]   = wdata_i[CMD_START];
    cmd_wr[CMD_RXRUN] = wdata_i[CMD_RXEN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      ena_q   <= '0;
      cmd_q   <= CMD_RST_VAL;
      lctl_q  <= '0;
      lerr_q  <= '0;
      act_q   <= '0;
      rst_q   <= 1'b0;
    end else begin
      rst_q <= wipe;
      if (wipe) begin
        cause_q <= '0;
        ena_q   <= '0;
        lerr_q  <= '0;
        act_q   <= '0;
        lctl_q  <= clr_i ? '0 : wdata_i;
      end else begin
        cause_q <= (cause_q & ~cause_clr) | evt_i;
        lerr_q  <= (lerr_q & ~lerr_clr) | err_i;
        if (wr_ena)  ena_q  <= wdata_i & ENA_MASK;
        if (wr_act)  act_q  <= act_q | wdata_i;
        if (wr_lctl) lctl_q <= wdata_i;
      end
      if (wr_cmd) cmd_q <= cmd_wr;
    end
  end

  always_comb begin
    unique case (off_i)
      P_CAUSE: rdata_o = cause_q;
      P_ENA:   rdata_o = ena_q;
      P_CMD:   rdata_o = cmd_q;
      P_LSTAT: rdata_o = present_i ? LINK_UP_VAL : '0;
      P_LCTL:  rdata_o = lctl_q;
      P_LERR:  rdata_o = lerr_q;
      P_ACT:   rdata_o = act_q;
      default: rdata_o = '0;
    endcase
  end

  assign pend_o     = |(cause_q & ena_q);
  assign run_o      = cmd_q[CMD_RUN];
  assign port_rst_o = rst_q;
endmodule

// File: rtl/hba_irq_agg.sv
module hba_irq_agg #(
  parameter int unsigned NPORTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              sum_wr_i,
  input  logic [31:0]       wdata_i,
  input  logic [NPORTS-1:0] pend_i,
  output logic              hba_rst_o,
  output logic [31:0]       ctl_o,
  output logic [31:0]       sum_o,
  output logic              irq_o
);
  logic [31:0] ctl_q, sum_q, sum_clr;
  logic        irq_q;

  assign hba_rst_o = ctl_wr_i && wdata_i[0];
  assign sum_clr   = sum_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      sum_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= (|sum_q) && ctl_q[1];
      if (hba_rst_o) begin
        ctl_q <= '0;
        sum_q <= '0;
      end else begin
        if (ctl_wr_i) ctl_q <= {1'b1, 29'd0, wdata_i[1:0]};
        // pending causes win over a same-cycle clear
        sum_q <= (sum_q & ~sum_clr) | 32'(pend_i);
      end
    end
  end

  assign ctl_o = ctl_q;
  assign sum_o = sum_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/hba_reg_file.sv
module hba_reg_file
  import hba_regs_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [32*NPORTS-1:0] port_evt_i,
  input  logic [32*NPORTS-1:0] port_err_i,
  input  logic [NPORTS-1:0]    port_present_i,
  output logic [NPORTS-1:0]    port_run_o,
  output logic [NPORTS-1:0]    port_rst_o,
  output logic                 irq_o
);
  localparam logic [31:0] CAP_VAL = cap_word(NPORTS, SLOTS);
  localparam logic [31:0] IMP_VAL = 32'((64'd1 << NPORTS) - 64'd1);

  logic        glob_hit, port_hit, aligned, wr_ok;
  logic [4:0]  port_idx;
  logic [6:0]  off;
  logic        ctl_wr_w, sum_wr_w, hba_rst_w;
  logic [31:0] ctl_w, sum_w;
  logic [NPORTS-1:0] pend_w;
  logic [31:0] p_rdata [NPORTS];

  hba_addr_dec #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) dec_i (
    .addr_i     (addr_i),
    .glob_hit_o (glob_hit),
    .port_hit_o (port_hit),
    .port_idx_o (port_idx),
    .off_o      (off),
    .aligned_o  (aligned)
  );

  assign wr_ok    = wr_i && aligned;
  assign ctl_wr_w = wr_ok && glob_hit && (off == G_CTL);
  assign sum_wr_w = wr_ok && glob_hit && (off == G_SUM);

  hba_irq_agg #(.NPORTS(NPORTS)) agg_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_wr_i  (ctl_wr_w),
    .sum_wr_i  (sum_wr_w),
    .wdata_i   (wdata_i),
    .pend_i    (pend_w),
    .hba_rst_o (hba_rst_w),
    .ctl_o     (ctl_w),
    .sum_o     (sum_w),
    .irq_o     (irq_o)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic sel_wr;
    assign sel_wr = wr_ok && port_hit && (port_idx == 5'(p));
    hba_port_regs port_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (hba_rst_w),
      .wr_i       (sel_wr),
      .off_i      (off),
      .wdata_i    (wdata_i),
      .evt_i      (port_evt_i[32*p +: 32]),
      .err_i      (port_err_i[32*p +: 32]),
      .present_i  (port_present_i[p]),
      .rdata_o    (p_rdata[p]),
      .pend_o     (pend_w[p]),
      .run_o      (port_run_o[p]),
      .port_rst_o (port_rst_o[p])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (glob_hit) begin
      unique case (off)
        G_CAP:   rdata_o = CAP_VAL;
        G_CTL:   rdata_o = ctl_w;
        G_SUM:   rdata_o = sum_w;
        G_IMP:   rdata_o = IMP_VAL;
        G_VER:   rdata_o = VER_VAL;
        default: rdata_o = '0;
      endcase
    end else if (port_hit) begin
      for (int p = 0; p < NPORTS; p++)
        if (port_idx == 5'(p)) rdata_o = p_rdata[p];
    end
  end
endmodule

// File: rtl/hba_reg_file_chk.sv
module hba_reg_file_chk #(
  parameter int unsigned NPORTS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [1:0]        addr_lo_i,
  input logic              irq_o,
  input logic [31:0]       ctl_i,
  input logic [31:0]       sum_i,
  input logic [NPORTS-1:0] pend_i,
  input logic              sum_wr_i,
  input logic              hba_rst_i
);
  // R8
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == ((|$past(sum_i)) && $past(ctl_i[1]))));

  // R7
  sum_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(sum_i) & ~sum_i) == '0) || $past(sum_wr_i) || $past(hba_rst_i)));

  // R7
  sum_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hba_rst_i |=> ((32'($past(pend_i)) & ~sum_i) == '0));

  // R2
  misaligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_lo_i != 2'b00)) |=> $stable(ctl_i));
endmodule

bind hba_reg_file hba_reg_file_chk #(.NPORTS(NPORTS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .addr_lo_i (addr_i[1:0]),
  .irq_o     (irq_o),
  .ctl_i     (ctl_w),
  .sum_i     (sum_w),
  .pend_i    (pend_w),
  .sum_wr_i  (sum_wr_w),
  .hba_rst_i (hba_rst_w)
);

// File: tb/hba_reg_file_tb_top.sv
`timescale 1ns/1ps
module hba_reg_file_tb_top;
  localparam int NP = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0;
  logic [31:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [32*NP-1:0] port_evt_i = '0;
  logic [32*NP-1:0] port_err_i = '0;
  logic [NP-1:0] port_present_i = 4'b1000;
  logic [NP-1:0] port_run_o, port_rst_o;
  logic          irq_o;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  hba_reg_file #(.NPORTS(NP), .SLOTS(32), .ADDR_W(32)) dut_i (.*);

  // monitor: compare what the design shows against queued expectations
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'd0, irq_o} : rdata_o;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk_i); #1;
    addr_i = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    repeat (3) @(posedge clk_i);
    #1;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
  endtask

  task automatic pulse_evt(input int p, input logic [31:0] v, input bit err);
    @(posedge clk_i); #1;
    if (err) port_err_i[32*p +: 32] = v; else port_evt_i[32*p +: 32] = v;
    @(posedge clk_i); #1;
    port_evt_i = '0; port_err_i = '0;
  endtask

  function automatic logic [31:0] pa(input int p, input logic [31:0] off);
    return 32'h100 + 32'h80 * p + off;
  endfunction

  initial begin : watchdog
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R3 constants and reset state
    rd(32'h00, 32'h4014_1F03, "R3 capability");
    rd(32'h0C, 32'h0000_000F, "R3 implemented");
    rd(32'h10, 32'h0001_0000, "R3 version");
    rd(32'h04, 32'h0, "R13 control reset value");
    rd(pa(0, 32'h18), 32'h6, "R9 command reset value");
    chk_irq(1'b0, "R8 irq after reset");
    // R4 control write
    wr(32'h04, 32'h2);
    rd(32'h04, 32'h8000_0002, "R4 control bits kept");
    rd(32'hFFFF_F004, 32'h8000_0002, "R1 high bits ignored");
    // R6 enable mask
    wr(pa(1, 32'h14), 32'hFFFF_FFFF);
    rd(pa(1, 32'h14), 32'hFDC0_00FF, "R6 enable mask");
    // R5 R7 R8 cause path
    pulse_evt(1, 32'h1, 1'b0);
    rd(pa(1, 32'h10), 32'h1, "R5 cause set");
    rd(32'h08, 32'h2, "R7 summary set");
    chk_irq(1'b1, "R8 irq raised");
    wr(pa(1, 32'h10), 32'h1);
    rd(pa(1, 32'h10), 32'h0, "R5 cause w1c");
    rd(32'h08, 32'h2, "R7 summary sticky");
    wr(32'h08, 32'h2);
    rd(32'h08, 32'h0, "R7 summary w1c");
    chk_irq(1'b0, "R8 irq dropped");
    // R7 disabled cause, then re-set while pending
    pulse_evt(2, 32'h20, 1'b0);
    rd(32'h08, 32'h0, "R7 disabled cause");
    wr(pa(2, 32'h14), 32'h20);
    rd(32'h08, 32'h4, "R7 enabled cause");
    wr(32'h08, 32'h4);
    rd(32'h08, 32'h4, "R7 re-set while pending");
    chk_irq(1'b1, "R8 irq with enable");
    wr(32'h04, 32'h0);
    rd(32'h04, 32'h8000_0000, "R4 enable bit cleared");
    chk_irq(1'b0, "R8 irq masked by control");
    wr(32'h04, 32'h2);
    // R2 misaligned writes
    wr(pa(2, 32'h15), 32'h0);
    rd(pa(2, 32'h14), 32'h20, "R2 misaligned port write");
    wr(32'h06, 32'h0);
    rd(32'h04, 32'h8000_0002, "R2 misaligned control write");
    // R9 command mirroring
    wr(pa(0, 32'h18), 32'h11);
    rd(pa(0, 32'h18), 32'h0000_C011, "R9 running bits follow enables");
    if (port_run_o[0] !== 1'b1) begin
      n_fail++; $display("FAIL R9 port_run_o: actual %b expected 1", port_run_o[0]);
    end
    n_chk++;
    wr(pa(0, 32'h18), 32'hC000);
    rd(pa(0, 32'h18), 32'h0, "R9 running bits not writable");
    // R10 link status
    rd(pa(3, 32'h28), 32'h113, "R10 present");
    rd(pa(0, 32'h28), 32'h0, "R10 absent");
    // R11 error and active
    pulse_evt(1, 32'hF00, 1'b1);
    rd(pa(1, 32'h30), 32'hF00, "R11 error set");
    wr(pa(1, 32'h30), 32'h300);
    rd(pa(1, 32'h30), 32'hC00, "R11 error w1c");
    wr(pa(1, 32'h34), 32'h3);
    wr(pa(1, 32'h34), 32'h4);
    rd(pa(1, 32'h34), 32'h7, "R11 active w1s");
    // R12 link control
    pulse_evt(1, 32'h2, 1'b0);
    wr(pa(1, 32'h2C), 32'h2);
    wr(pa(1, 32'h2C), 32'h0);
    rd(pa(1, 32'h14), 32'hFDC0_00FF, "R12 no reset on 2->0");
    wr(pa(1, 32'h2C), 32'h1);
    wr(pa(1, 32'h2C), 32'h300);
    rd(pa(1, 32'h2C), 32'h300, "R12 control keeps value");
    rd(pa(1, 32'h14), 32'h0, "R12 enable cleared");
    rd(pa(1, 32'h10), 32'h0, "R12 cause cleared");
    rd(pa(1, 32'h30), 32'h0, "R12 error cleared");
    rd(pa(1, 32'h34), 32'h0, "R12 active cleared");
    rd(pa(1, 32'h18), 32'h6, "R12 command kept");
    // R1 decode holes
    rd(32'h300, 32'h0, "R1 port out of range");
    rd(32'h1C, 32'h0, "R1 unknown controller offset");
    rd(pa(0, 32'h20), 32'h0, "R1 unknown port offset");
    // R13 controller reset
    wr(pa(0, 32'h18), 32'h10);
    wr(32'h04, 32'h1);
    rd(32'h04, 32'h0, "R13 control cleared");
    rd(32'h08, 32'h0, "R13 summary cleared");
    rd(pa(2, 32'h14), 32'h0, "R13 port enable cleared");
    rd(pa(1, 32'h2C), 32'h0, "R13 link control cleared");
    rd(pa(0, 32'h18), 32'h4010, "R13 command kept");
    chk_irq(1'b0, "R13 irq low after reset");
    repeat (2) @(posedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule